// File: doc/BRIEF.md
# Knob-Tuned Oscillator Frequency Controller

This block turns a potentiometer reading and a single push-button into the frequency word for a variable oscillator. The sample is doubled and becomes a fine offset that is added to a stored base frequency. The default base sits so that a centred knob produces the nominal frequency. Each press of the button moves the base by a coarse step. The step goes down when the knob is in its lower half and up when it is in its upper half. Every step is saved to a small byte-wide nonvolatile memory, so the tuning range grows and the setting survives a power cycle.

The block works on a fixed sampling tick. When it is not handling a press, it issues a new word only when the doubled sample differs from the one it used last. Reset marks the last-used value as impossible, so the first valid sample always produces a word. Each word goes out with a one-cycle strobe to a downstream synthesizer programmer. The word is held until that programmer signals completion.

At power-up the block reads a marker byte to decide whether the stored base can be trusted. Holding the button through power-up first waits for the release. It then writes the default base and the marker, which restores the factory setting.

Top module: `knob_osc_ctrl`

## Requirements
- R1: On every update strobe, `freq_word` equals the current base plus twice the latched 10-bit sample, so the fine offset spans 0 to 2046 in steps of 2.
- R2: When the byte at address 0x0F is not 0x49 at start-up, the base is NOMINAL_HZ minus (2^ADC_W - 1). With ADC_W=10 this is NOMINAL_HZ-1023, which makes the knob's mid position give the nominal frequency.
- R3: On a tick with the button low (pressed), the base falls by STEP_HZ if the doubled sample is below 2^ADC_W (1024) and otherwise rises by STEP_HZ. One strobe then follows, carrying the new base plus the doubled sample.
- R4: After a step, the new base is written as four bytes to addresses 0,1,2,3 in that order, least significant byte at address 0. The strobe comes only after the last of these writes is acknowledged, and never while a write request is open. Address 0x0F is not touched.
- R5: After a step, no further step, strobe or memory access happens until the button has returned high.
- R6: With the button released, a strobe is issued only when the doubled sample differs from the last value used. No strobe is issued before the first valid sample, and the first valid sample after reset always produces one.
- R7: Decisions are taken only on a sampling tick every TICK_CYCLES clock cycles. Strobes from the normal path are therefore spaced by whole multiples of TICK_CYCLES.
- R8: If the button is low when `power_good` is first seen, the block waits for release. It then writes the default base to addresses 0..3 and writes 0x49 to address 0x0F, in that order, and runs with the default base.
- R9: At start-up, address 0x0F is read. If it holds 0x49, the base is loaded from addresses 0..3 (LSB first) with no write.
- R10: `freq_upd` is a single-cycle pulse. `freq_word` stays unchanged, and no further strobe is issued, from the strobe until `synth_done` is seen.
- R11: A memory request keeps `nvm_req`, `nvm_we`, `nvm_addr` and `nvm_wdata` constant until `nvm_ack` arrives. `nvm_rdata` is taken in the `nvm_ack` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| power_good | input | 1 | High once supply is stable; starts the boot sequence |
| adc_sample | input | ADC_W | Potentiometer sample |
| adc_valid | input | 1 | One-cycle strobe marking a new sample |
| skip_n | input | 1 | Debounced coarse-step button, low when pressed |
| nvm_req | output | 1 | Memory access request, held until acknowledged |
| nvm_we | output | 1 | High for a write, low for a read |
| nvm_addr | output | NVM_AW | Memory byte address |
| nvm_wdata | output | 8 | Write data |
| nvm_ack | input | 1 | One-cycle completion of the current access |
| nvm_rdata | input | 8 | Read data, valid with nvm_ack |
| freq_word | output | FREQ_W | Frequency word for the synthesizer programmer |
| freq_upd | output | 1 | One-cycle strobe: new frequency word |
| synth_done | input | 1 | Programmer finished with the current word |

## Verification
The bench builds the block with a 4-bit sample and a 16-cycle sampling tick. The small sample width allows every sample value to be swept twice. The first sweep covers the plain fine-tuning path. The second presses the button at each value, so the step direction is checked at every point, including the boundary between the two halves of the knob. The short tick keeps boot, four-byte saves and release waits to a few hundred cycles. Separate boots cover a valid marker, a wrong marker and the button-held restore.

// File: rtl/knob_osc_ctrl.sv
module knob_osc_ctrl #(
  parameter int ADC_W       = 10,
  parameter int FREQ_W      = 32,
  parameter int NVM_AW      = 4,
  parameter int NOMINAL_HZ  = 14_000_000,
  parameter int STEP_HZ     = 1000,
  parameter int TICK_CYCLES = 3_000_000,
  parameter int MARK_ADDR   = 15,
  parameter int MARK_VAL    = 8'h49
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_good,
  input  logic [ADC_W-1:0]  adc_sample,
  input  logic              adc_valid,
  input  logic              skip_n,
  output logic              nvm_req,
  output logic              nvm_we,
  output logic [NVM_AW-1:0] nvm_addr,
  output logic [7:0]        nvm_wdata,
  input  logic              nvm_ack,
  input  logic [7:0]        nvm_rdata,
  output logic [FREQ_W-1:0] freq_word,
  output logic              freq_upd,
  input  logic              synth_done
);
  localparam int DW    = ADC_W + 1;
  localparam int TCW   = $clog2(TICK_CYCLES + 1);
  localparam int BYTES = FREQ_W / 8;
  localparam int IDXW  = $clog2(BYTES + 1);
  localparam logic [FREQ_W-1:0] DEF_BASE = FREQ_W'(NOMINAL_HZ - (2**ADC_W - 1));
  localparam logic [DW-1:0]     MID      = DW'(2**ADC_W);
  localparam logic [DW-1:0]     NONE     = '1;
  localparam logic [7:0]        MARK     = 8'(MARK_VAL);

  typedef enum logic [3:0] {
    ST_PWR, ST_BOOT_HOLD, ST_INIT_WR, ST_RD_MARK, ST_RD_BASE,
    ST_RUN, ST_SKIP_WR, ST_UPD_WAIT, ST_REL
  } st_t;

  st_t               st;
  logic [TCW-1:0]    tcnt;
  logic              tick;
  logic [ADC_W-1:0]  samp;
  logic              have;
  logic [DW-1:0]     dbl, last;
  logic [FREQ_W-1:0] base, target, stepped;
  logic [IDXW-1:0]   idx;
  logic              after_skip;
  logic [7:0]        cur_byte;

  assign tick    = (tcnt == TCW'(TICK_CYCLES - 1));
  assign dbl     = {samp, 1'b0};
  assign target  = base + FREQ_W'(dbl);
  assign stepped = (dbl < MID) ? base - FREQ_W'(STEP_HZ) : base + FREQ_W'(STEP_HZ);

  always_comb begin
    cur_byte = '0;
    for (int b = 0; b < BYTES; b++)
      if (idx == IDXW'(b)) cur_byte = base[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    tcnt <= '0;
    else if (tick) tcnt <= '0;
    else           tcnt <= tcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      samp <= '0;
      have <= 1'b0;
    end else if (adc_valid) begin
      samp <= adc_sample;
      have <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_PWR;
      base       <= DEF_BASE;
      last       <= NONE;
      idx        <= '0;
      after_skip <= 1'b0;
      nvm_req    <= 1'b0;
      nvm_we     <= 1'b0;
      nvm_addr   <= '0;
      nvm_wdata  <= '0;
      freq_word  <= '0;
      freq_upd   <= 1'b0;
    end else begin
      freq_upd <= 1'b0;
      case (st)
        ST_PWR:
          if (power_good) st <= skip_n ? ST_RD_MARK : ST_BOOT_HOLD;
        ST_BOOT_HOLD:
          if (skip_n) begin
            base <= DEF_BASE;
            idx  <= '0;
            st   <= ST_INIT_WR;
          end
        ST_INIT_WR:
          if (!nvm_req) begin
            nvm_req   <= 1'b1;
            nvm_we    <= 1'b1;
            nvm_addr  <= (idx == IDXW'(BYTES)) ? NVM_AW'(MARK_ADDR) : NVM_AW'(idx);
            nvm_wdata <= (idx == IDXW'(BYTES)) ? MARK : cur_byte;
          end else if (nvm_ack) begin
            nvm_req <= 1'b0;
            if (idx == IDXW'(BYTES)) st <= ST_RD_MARK;
            else                     idx <= idx + 1'b1;
          end
        ST_RD_MARK:
          if (!nvm_req) begin
            nvm_req  <= 1'b1;
            nvm_we   <= 1'b0;
            nvm_addr <= NVM_AW'(MARK_ADDR);
          end else if (nvm_ack) begin
            nvm_req <= 1'b0;
            idx     <= '0;
            st      <= (nvm_rdata == MARK) ? ST_RD_BASE : ST_RUN;
          end
        ST_RD_BASE:
          if (!nvm_req) begin
            nvm_req  <= 1'b1;
            nvm_we   <= 1'b0;
            nvm_addr <= NVM_AW'(idx);
          end else if (nvm_ack) begin
            nvm_req <= 1'b0;
            for (int b = 0; b < BYTES; b++)
              if (idx == IDXW'(b)) base[8*b +: 8] <= nvm_rdata;
            if (idx == IDXW'(BYTES - 1)) st <= ST_RUN;
            else                         idx <= idx + 1'b1;
          end
        ST_RUN:
          if (tick && have) begin
            if (!skip_n) begin
              base <= stepped;
              idx  <= '0;
              st   <= ST_SKIP_WR;
            end else if (dbl != last) begin
              freq_word  <= target;
              freq_upd   <= 1'b1;
              last       <= dbl;
              after_skip <= 1'b0;
              st         <= ST_UPD_WAIT;
            end
          end
        ST_SKIP_WR:
          if (!nvm_req) begin
            nvm_req   <= 1'b1;
            nvm_we    <= 1'b1;
            nvm_addr  <= NVM_AW'(idx);
            nvm_wdata <= cur_byte;
          end else if (nvm_ack) begin
            nvm_req <= 1'b0;
            if (idx == IDXW'(BYTES - 1)) begin
              freq_word  <= target;
              freq_upd   <= 1'b1;
              last       <= dbl;
              after_skip <= 1'b1;
              st         <= ST_UPD_WAIT;
            end else idx <= idx + 1'b1;
          end
        ST_UPD_WAIT:
          if (synth_done) st <= after_skip ? ST_REL : ST_RUN;
        ST_REL:
          if (skip_n) st <= ST_RUN;
        default: st <= ST_PWR;
      endcase
    end
  end

  // R4
  no_strobe_during_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_req && nvm_we) |-> !freq_upd);

  // R10
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_upd |=> !freq_upd);

  // R10
  upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_UPD_WAIT && !synth_done) |=> (!freq_upd && $stable(freq_word)));

  // R11
  nvm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_req && !nvm_ack) |=> (nvm_req && $stable(nvm_we) && $stable(nvm_addr) && $stable(nvm_wdata)));

  // R4
  nvm_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_req |-> (nvm_addr < NVM_AW'(BYTES) || nvm_addr == NVM_AW'(MARK_ADDR)));

  // R8
  mark_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nvm_req && nvm_we && nvm_addr == NVM_AW'(MARK_ADDR)) |-> nvm_wdata == MARK);

  // R5
  rel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REL) |=> (!freq_upd && !nvm_req));
endmodule

// File: tb/knob_osc_ctrl_test.sv
`timescale 1ns/100ps
module knob_osc_ctrl_test;
  localparam int AW  = 4;
  localparam int TK  = 16;
  localparam int NOM = 14_000_000;
  localparam longint DEF = NOM - (2**AW - 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic power_good = 1'b1;
  logic [AW-1:0] adc_sample = '0;
  logic adc_valid = 1'b0;
  logic skip_n = 1'b1;
  logic nvm_req, nvm_we;
  logic [3:0] nvm_addr;
  logic [7:0] nvm_wdata;
  logic nvm_ack = 1'b0;
  logic [7:0] nvm_rdata = '0;
  logic [31:0] freq_word;
  logic freq_upd;
  logic synth_done = 1'b0;

  always #2.5 clk = ~clk;

  knob_osc_ctrl #(.ADC_W(AW), .TICK_CYCLES(TK)) uut (
    .clk(clk), .rst_n(rst_n), .power_good(power_good),
    .adc_sample(adc_sample), .adc_valid(adc_valid), .skip_n(skip_n),
    .nvm_req(nvm_req), .nvm_we(nvm_we), .nvm_addr(nvm_addr), .nvm_wdata(nvm_wdata),
    .nvm_ack(nvm_ack), .nvm_rdata(nvm_rdata),
    .freq_word(freq_word), .freq_upd(freq_upd), .synth_done(synth_done));

  logic [7:0] mem [0:15];
  int mem_dly = 0;
  int wcount = 0;
  int wlog [0:255];
  logic pre_go = 1'b0;
  logic [31:0] pre_val = '0;
  logic [7:0] pre_mark = '0;

  always @(posedge clk) begin
    nvm_ack <= 1'b0;
    if (pre_go) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'h00;
      for (int i = 0; i < 4; i++) mem[i] <= pre_val[8*i +: 8];
      mem[15] <= pre_mark;
    end else if (nvm_req && !nvm_ack) begin
      if (mem_dly == 2) begin
        mem_dly <= 0;
        nvm_ack <= 1'b1;
        if (nvm_we) begin
          mem[nvm_addr] <= nvm_wdata;
          wlog[wcount % 256] <= int'(nvm_addr);
          wcount <= wcount + 1;
        end else nvm_rdata <= mem[nvm_addr];
      end else mem_dly <= mem_dly + 1;
    end
  end

  int upd_cnt = 0;
  int upd_in_wr = 0;
  int done_dly = 0;
  longint cyc = 0, upd_cyc = 0, prev_upd_cyc = 0;
  logic [31:0] last_word = '0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    synth_done <= 1'b0;
    if (freq_upd) begin
      upd_cnt <= upd_cnt + 1;
      last_word <= freq_word;
      prev_upd_cyc <= upd_cyc;
      upd_cyc <= cyc;
      done_dly <= 3;
      if (nvm_req && nvm_we) upd_in_wr <= upd_in_wr + 1;
    end else if (done_dly > 0) begin
      done_dly <= done_dly - 1;
      if (done_dly == 1) synth_done <= 1'b1;
    end
  end

  int checks = 0, fails = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive_sample(int s);
    @(negedge clk);
    adc_sample = AW'(s);
    adc_valid = 1'b1;
    @(negedge clk);
    adc_valid = 1'b0;
  endtask

  task automatic do_reset(logic [31:0] v, logic [7:0] m, bit hold);
    @(negedge clk);
    rst_n = 1'b0;
    skip_n = !hold;
    pre_val = v;
    pre_mark = m;
    pre_go = 1'b1;
    @(negedge clk);
    pre_go = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
  endtask

  function automatic longint mem_base();
    return {mem[3], mem[2], mem[1], mem[0]};
  endfunction

  task automatic run_all();
    int u0, w0;
    longint eb;
    // reset state, power not yet good
    power_good = 1'b0;
    do_reset(32'd0, 8'h00, 0);
    wait_cyc(3 * TK);
    chk("R6", "strobe low in reset state", freq_upd, 0);
    chk("R6", "no memory request before power_good", nvm_req, 0);
    chk("R6", "word zero after reset", freq_word, 0);
    power_good = 1'b1;
    wait_cyc(6 * TK);
    chk("R6", "no strobe before first sample", upd_cnt, 0);
    chk("R2", "no writes on plain boot", wcount, 0);

    // fine sweep, R1/R2/R7/R10
    for (int s = 0; s < 2**AW; s++) begin
      u0 = upd_cnt;
      drive_sample(s);
      wait_cyc(3 * TK);
      chk("R6", $sformatf("one strobe for new sample %0d", s), upd_cnt - u0, 1);
      chk("R1", $sformatf("word for sample %0d", s), last_word, DEF + 2 * s);
      chk("R10", "word held after strobe", freq_word, DEF + 2 * s);
      if (s > 0) chk("R7", "strobe spacing multiple of tick", (upd_cyc - prev_upd_cyc) % TK, 0);
    end
    u0 = upd_cnt;
    drive_sample(2**AW - 1);
    wait_cyc(4 * TK);
    chk("R6", "repeated sample gives no strobe", upd_cnt - u0, 0);

    // coarse steps at every sample value
    eb = DEF;
    for (int s = 0; s < 2**AW; s++) begin
      drive_sample(s);
      wait_cyc(3 * TK);
      u0 = upd_cnt;
      w0 = wcount;
      skip_n = 1'b0;
      wait_cyc(4 * TK);
      if (s == 0) wait_cyc(8 * TK);
      eb = (2 * s < 2**AW) ? eb - 1000 : eb + 1000;
      chk("R3", $sformatf("one strobe per press at sample %0d", s), upd_cnt - u0, 1);
      chk("R3", $sformatf("stepped word at sample %0d", s), last_word, eb + 2 * s);
      chk("R5", "exactly four writes while held", wcount - w0, 4);
      chk("R4", "stored base LSB first", mem_base(), eb);
      for (int k = 0; k < 4; k++) chk("R4", "write address order", wlog[(w0 + k) % 256], k);
      chk("R4", "marker untouched by step", mem[15], 0);
      skip_n = 1'b1;
      wait_cyc(3 * TK);
      chk("R5", "no strobe after release", upd_cnt - u0, 1);
    end
    chk("R4", "no strobe during open write", upd_in_wr, 0);

    // valid marker boot
    do_reset(32'd7_050_000, 8'h49, 0);
    w0 = wcount;
    u0 = upd_cnt;
    wait_cyc(8 * TK);
    chk("R6", "no strobe before sample after boot", upd_cnt - u0, 0);
    drive_sample(5);
    wait_cyc(3 * TK);
    chk("R9", "stored base loaded", last_word, 7_050_010);
    chk("R9", "no writes on loading boot", wcount - w0, 0);

    // wrong marker boot
    do_reset(32'd7_050_000, 8'h48, 0);
    wait_cyc(8 * TK);
    drive_sample(5);
    wait_cyc(3 * TK);
    chk("R2", "default base with wrong marker", last_word, DEF + 10);

    // button held through power-up
    do_reset(32'd7_050_000, 8'h49, 1);
    w0 = wcount;
    u0 = upd_cnt;
    wait_cyc(6 * TK);
    chk("R8", "no writes while held at boot", wcount - w0, 0);
    skip_n = 1'b1;
    wait_cyc(8 * TK);
    chk("R8", "five restore writes", wcount - w0, 5);
    for (int k = 0; k < 4; k++) chk("R8", "restore address order", wlog[(w0 + k) % 256], k);
    chk("R8", "marker written last", wlog[(w0 + 4) % 256], 15);
    chk("R8", "default base stored", mem_base(), DEF);
    chk("R8", "marker value", mem[15], 8'h49);
    drive_sample(9);
    wait_cyc(3 * TK);
    chk("R8", "runs on default base", last_word, DEF + 18);
    chk("R6", "single strobe after restore", upd_cnt - u0, 1);
  endtask

  initial begin
    bit timed_out = 0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule